// File: doc/BRIEF.md
# Checkerboard Tile Triangle Distributor

This block sits between triangle setup and two rasterizer engines. Each incoming triangle arrives as an integer pixel bounding box and an identifier. The screen is cut into square tiles 8 pixels on a side, and the two engines own these tiles in a checkerboard. As a result, any two tiles that touch along an edge belong to different engines. The distributor finds which engines own tiles under the bounding box and writes the triangle into the queue of each of them.

Each engine has a private first-in first-out queue, 8 entries deep, with its own valid/ready handshake toward the engine. The input side also uses valid/ready. A triangle is taken from the input only after every queue it targets has stored it. When one target queue has room and the other is full, the queue with room takes its copy at once and is never written again for that triangle. The input then stalls until the other copy lands.

Top module: `tile_tri_dist`

## Requirements
- R1: A bounding box inside a single tile is written only to queue 0 when bit 0 of ((xmin>>3) XOR (ymin>>3)) is 0. Queue 1 does not receive it.
- R2: A bounding box inside a single tile is written only to queue 1 when that parity bit is 1. Queue 0 does not receive it.
- R3: A box whose min and max fall in different tile columns (x>>3) or different tile rows (y>>3) is written to both queues.
- R4: Each queue delivers its triangles in the order they were accepted at the input. A queue's output holds valid and data steady while ready is low.
- R5: Each queue stores 8 entries. While a target queue is full, in_ready is low and nothing is lost.
- R6: A triangle for both queues is accepted only after both queues have stored it. A queue that stored it early gets no second copy.
- R7: After reset both queues are empty (q0_valid and q1_valid low) and in_ready is high.
- R8: Box and ID reach the output unchanged: qN_box = {xmin, ymin, xmax, ymax}, 12 bits each with xmin in the top bits, and qN_id = in_id.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Triangle offered |
| in_ready | output | 1 | Triangle accepted this cycle when valid |
| in_xmin | input | 12 | Box left pixel |
| in_ymin | input | 12 | Box top pixel |
| in_xmax | input | 12 | Box right pixel (>= xmin) |
| in_ymax | input | 12 | Box bottom pixel (>= ymin) |
| in_id | input | 8 | Triangle identifier |
| q0_valid | output | 1 | Queue 0 head valid |
| q0_ready | input | 1 | Engine 0 takes head |
| q0_box | output | 48 | Queue 0 head box {xmin,ymin,xmax,ymax} |
| q0_id | output | 8 | Queue 0 head ID |
| q1_valid | output | 1 | Queue 1 head valid |
| q1_ready | input | 1 | Engine 1 takes head |
| q1_box | output | 48 | Queue 1 head box {xmin,ymin,xmax,ymax} |
| q1_id | output | 8 | Queue 1 head ID |

## Verification
The hardest case to reach is a two-target triangle where one queue has room and the other is full. In that case one copy lands early and the input has to wait for the second. The stimulus holds engine 1's ready low and fills its queue with eight odd-parity triangles. It then offers a box that spans a tile boundary and checks that in_ready stays low across several cycles. Next it releases engine 1 and confirms through the scoreboard that queue 0 emits exactly one copy. A separate phase fills queue 0 to exactly eight entries and probes the stall on the ninth.

// File: rtl/tdist_pkg.sv
package tdist_pkg;

   localparam int NQ = 2;

   typedef logic [NQ-1:0] qmask_t;

   // parity of the tile indices picks the owning engine
   function automatic logic tile_owner(input logic tx_lsb, input logic ty_lsb);
      return tx_lsb ^ ty_lsb;
   endfunction

   function automatic qmask_t owner_mask(input logic owner);
      qmask_t m;
      m = '0;
      m[owner] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/tdist_route.sv
module tdist_route
   import tdist_pkg::*;
#(
   parameter int COORD_W   = 12,
   parameter int TILE_LOG2 = 3
) (
   input  logic [COORD_W-1:0] xmin,
   input  logic [COORD_W-1:0] ymin,
   input  logic [COORD_W-1:0] xmax,
   input  logic [COORD_W-1:0] ymax,
   output qmask_t             mask,
   output logic               span
);

   localparam int TIDX_W = COORD_W - TILE_LOG2;

   if (TILE_LOG2 < 1 || TILE_LOG2 >= COORD_W) begin : g_bad_tile
      $error("tdist_route: TILE_LOG2 must lie in 1..COORD_W-1");
   end

   logic [TIDX_W-1:0] tx_lo, tx_hi, ty_lo, ty_hi;
   logic              own;

   assign tx_lo = xmin[COORD_W-1:TILE_LOG2];
   assign tx_hi = xmax[COORD_W-1:TILE_LOG2];
   assign ty_lo = ymin[COORD_W-1:TILE_LOG2];
   assign ty_hi = ymax[COORD_W-1:TILE_LOG2];

   assign span = (tx_lo != tx_hi) || (ty_lo != ty_hi);
   assign own  = tile_owner(tx_lo[0], ty_lo[0]);

   always_comb begin
      if (span) mask = '1;
      else      mask = owner_mask(own);
   end

endmodule

// File: rtl/tdist_issue.sv
module tdist_issue
   import tdist_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   in_valid,
   input  qmask_t mask,
   input  qmask_t q_full,
   output qmask_t push,
   output logic   in_ready
);

   qmask_t sent_q, sent_d, need;
   logic   fire;

   assign need = mask & ~sent_q;

   for (genvar g = 0; g < NQ; g++) begin : g_push
      assign push[g] = in_valid & need[g] & ~q_full[g];
   end

   assign in_ready = &(~need | ~q_full);
   assign fire     = in_valid & in_ready;

   always_comb begin
      if (fire)          sent_d = '0;
      else if (in_valid) sent_d = sent_q | push;
      else               sent_d = sent_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) sent_q <= '0;
      else        sent_q <= sent_d;
   end

   // R6
   sent_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_ready) |=> ((sent_q & $past(sent_q)) == $past(sent_q)));

endmodule

// File: rtl/tdist_fifo.sv
module tdist_fifo #(
   parameter int W     = 56,
   parameter int DEPTH = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wdata,
   output logic         full,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] rdata
);

   localparam int AW = $clog2(DEPTH);

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("tdist_fifo: DEPTH must be a power of two >= 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [AW:0]   count;
   logic          pop;

   assign pop       = out_valid & out_ready;
   assign out_valid = (count != '0);
   assign full      = (count == (AW+1)'(DEPTH));
   assign rdata     = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   // R5
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);

   // R4
   head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(rdata)));

endmodule

// File: rtl/tile_tri_dist.sv
module tile_tri_dist
   import tdist_pkg::*;
#(
   parameter int COORD_W    = 12,
   parameter int ID_W       = 8,
   parameter int TILE_LOG2  = 3,
   parameter int FIFO_DEPTH = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic [COORD_W-1:0]   in_xmin,
   input  logic [COORD_W-1:0]   in_ymin,
   input  logic [COORD_W-1:0]   in_xmax,
   input  logic [COORD_W-1:0]   in_ymax,
   input  logic [ID_W-1:0]      in_id,
   output logic                 q0_valid,
   input  logic                 q0_ready,
   output logic [4*COORD_W-1:0] q0_box,
   output logic [ID_W-1:0]      q0_id,
   output logic                 q1_valid,
   input  logic                 q1_ready,
   output logic [4*COORD_W-1:0] q1_box,
   output logic [ID_W-1:0]      q1_id
);

   localparam int BOX_W   = 4 * COORD_W;
   localparam int ENTRY_W = BOX_W + ID_W;

   if (ID_W < 1) begin : g_bad_id
      $error("tile_tri_dist: ID_W must be positive");
   end

   qmask_t mask, push, full;
   logic   span;
   logic   [ENTRY_W-1:0] entry;
   logic   [ENTRY_W-1:0] head  [NQ];
   logic   [NQ-1:0]      hvalid, hready;

   assign entry = {in_xmin, in_ymin, in_xmax, in_ymax, in_id};

   tdist_route #(
      .COORD_W  (COORD_W),
      .TILE_LOG2(TILE_LOG2)
   ) u_route (
      .xmin(in_xmin),
      .ymin(in_ymin),
      .xmax(in_xmax),
      .ymax(in_ymax),
      .mask(mask),
      .span(span)
   );

   tdist_issue u_issue (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_valid(in_valid),
      .mask    (mask),
      .q_full  (full),
      .push    (push),
      .in_ready(in_ready)
   );

   assign hready = {q1_ready, q0_ready};

   for (genvar g = 0; g < NQ; g++) begin : g_q
      tdist_fifo #(
         .W    (ENTRY_W),
         .DEPTH(FIFO_DEPTH)
      ) u_fifo (
         .clk      (clk),
         .rst_n    (rst_n),
         .push     (push[g]),
         .wdata    (entry),
         .full     (full[g]),
         .out_valid(hvalid[g]),
         .out_ready(hready[g]),
         .rdata    (head[g])
      );
   end

   assign q0_valid = hvalid[0];
   assign q1_valid = hvalid[1];
   assign q0_box   = head[0][ENTRY_W-1:ID_W];
   assign q0_id    = head[0][ID_W-1:0];
   assign q1_box   = head[1][ENTRY_W-1:ID_W];
   assign q1_id    = head[1][ID_W-1:0];

   // R1
   owner_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push & ~mask) == '0);

   // R3
   dual_needs_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push[0] && push[1]) |-> span);

endmodule

// File: tb/tile_tri_dist_bench.sv
module tile_tri_dist_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic        in_ready;
   logic [11:0] in_xmin, in_ymin, in_xmax, in_ymax;
   logic [7:0]  in_id;
   logic        q0_valid, q1_valid;
   logic        q0_ready, q1_ready;
   logic [47:0] q0_box, q1_box;
   logic [7:0]  q0_id, q1_id;

   always #4 clk = ~clk;

   tile_tri_dist u_tile_tri_dist (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready),
      .in_xmin(in_xmin), .in_ymin(in_ymin), .in_xmax(in_xmax), .in_ymax(in_ymax),
      .in_id(in_id),
      .q0_valid(q0_valid), .q0_ready(q0_ready), .q0_box(q0_box), .q0_id(q0_id),
      .q1_valid(q1_valid), .q1_ready(q1_ready), .q1_box(q1_box), .q1_id(q1_id)
   );

   int applied = 0;
   int errors  = 0;

   logic [55:0] exp0[$], exp1[$];
   string       tag0[$], tag1[$];

   // ready modes: 0 always, 1 held low, 2 pseudo-random
   int          rmode0 = 0, rmode1 = 0;
   logic [15:0] lfsr = 16'hACE1;

   always @(posedge clk) begin
      lfsr     <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      q0_ready <= (rmode0 == 0) ? 1'b1 : (rmode0 == 1) ? 1'b0 : lfsr[3];
      q1_ready <= (rmode1 == 0) ? 1'b1 : (rmode1 == 1) ? 1'b0 : lfsr[9];
   end

   task automatic check(input string req, input logic [55:0] act, input logic [55:0] exp);
      applied++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // scoreboard monitors
   always @(negedge clk) begin
      if (rst_n && q0_valid && q0_ready) begin
         if (exp0.size() == 0) check("R1", {q0_box, q0_id}, 56'hx);
         else check(tag0.pop_front(), {q0_box, q0_id}, exp0.pop_front());
      end
      if (rst_n && q1_valid && q1_ready) begin
         if (exp1.size() == 0) check("R2", {q1_box, q1_id}, 56'hx);
         else check(tag1.pop_front(), {q1_box, q1_id}, exp1.pop_front());
      end
   end

   function automatic logic [1:0] exp_mask(input logic [11:0] x0, y0, x1, y1);
      if ((x0 / 8) != (x1 / 8) || (y0 / 8) != (y1 / 8)) return 2'b11;
      return (((x0 / 8) + (y0 / 8)) % 2 == 0) ? 2'b01 : 2'b10;
   endfunction

   task automatic offer(input logic [11:0] x0, y0, x1, y1, input logic [7:0] id, input string req);
      logic [1:0] m;
      m = exp_mask(x0, y0, x1, y1);
      if (m[0]) begin exp0.push_back({x0, y0, x1, y1, id}); tag0.push_back(req); end
      if (m[1]) begin exp1.push_back({x0, y0, x1, y1, id}); tag1.push_back(req); end
      @(negedge clk);
      in_valid = 1'b1;
      in_xmin = x0; in_ymin = y0; in_xmax = x1; in_ymax = y1; in_id = id;
   endtask

   task automatic complete();
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic send(input logic [11:0] x0, y0, x1, y1, input logic [7:0] id, input string req);
      offer(x0, y0, x1, y1, id, req);
      complete();
   endtask

   task automatic drain();
      int n;
      n = 0;
      while ((exp0.size() != 0 || exp1.size() != 0) && n < 2000) begin
         @(negedge clk);
         n++;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", applied, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; in_valid = 1'b0;
      in_xmin = '0; in_ymin = '0; in_xmax = '0; in_ymax = '0; in_id = '0;
      repeat (4) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      // R7
      check("R7", {53'd0, q0_valid, q1_valid, in_ready}, 56'd1);

      // R1 / R2 single-tile parity, R8 content
      send(0, 0, 7, 7, 8'h01, "R1");
      send(8, 0, 15, 7, 8'h02, "R2");
      send(8, 8, 12, 13, 8'h03, "R1");
      send(0, 8, 3, 15, 8'h04, "R2");
      send(4088, 4088, 4095, 4095, 8'h05, "R1");
      send(4080, 4088, 4087, 4095, 8'h06, "R2");
      send(16, 40, 16, 40, 8'h07, "R8");
      // R3 spans
      send(4, 0, 9, 5, 8'h10, "R3");
      send(0, 6, 3, 9, 8'h11, "R3");
      send(4087, 4087, 4088, 4088, 8'h12, "R3");
      send(0, 0, 4095, 4095, 8'h13, "R3");
      drain();

      // R4 random ordering with random backpressure
      rmode0 = 2; rmode1 = 2;
      for (int i = 0; i < 80; i++) begin
         logic [11:0] x, y, w, h;
         x = 12'($urandom_range(0, 4095));
         y = 12'($urandom_range(0, 4095));
         w = 12'($urandom_range(0, 9));
         h = 12'($urandom_range(0, 9));
         if (x > 4095 - w) x = 4095 - w;
         if (y > 4095 - h) y = 4095 - h;
         send(x, y, x + w, y + h, 8'(i), "R4");
      end
      rmode0 = 0; rmode1 = 0;
      drain();

      // R5 fill queue 0 with 8, ninth stalls
      rmode0 = 1;
      @(negedge clk); @(negedge clk);
      for (int i = 0; i < 8; i++) send(0, 0, 1, 1, 8'(8'h40 + i), "R5");
      offer(8, 8, 9, 9, 8'h48, "R5");
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         check("R5", {55'd0, in_ready}, 56'd0);
      end
      rmode0 = 0;
      complete();
      drain();

      // R6 dual target with queue 1 full
      rmode1 = 1;
      @(negedge clk); @(negedge clk);
      for (int i = 0; i < 8; i++) send(8, 0, 8, 0, 8'(8'h50 + i), "R6");
      offer(6, 6, 10, 10, 8'h58, "R6");
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         check("R6", {55'd0, in_ready}, 56'd0);
      end
      rmode1 = 0;
      complete();
      send(0, 0, 0, 0, 8'h59, "R6");
      drain();
      repeat (10) @(negedge clk);
      check("R6", {24'd0, 32'(exp0.size() + exp1.size())}, 56'd0);
      check("R4", {54'd0, q0_valid, q1_valid}, 56'd0);

      $display("  == %0d vectors applied, %0d miscompares ==", applied, errors);
      $finish;
   end

endmodule